// File: doc/BRIEF.md
# Ripple-Carry Adder Self-Test Sequencer

This block runs a built-in self-test of an external 32-bit adder whose carry into bit 0 is held at zero. After a start pulse it drives ten fixed operand pairs, one after another. The pairs are built from all-zero, all-one, alternating-bit and single-LSB patterns. Together they make every full-adder cell above bit 0 see all eight combinations of its two operand bits and its incoming carry. A carry into a cell is forced low by making both operand bits of the cell below it zero. It is forced high by making both of them one. This holds whatever carry enters the lower cell.

For each pair the block holds the operands steady for a settle interval, then compares the adder's result against its own modulo-2^W sum. The settle interval is a cycle count derived from the clock period and a 100 ns nominal vector period. The first mismatch latches a fail flag and the 1-based number of that vector. The run still finishes all ten pairs and counts every mismatch. When the run ends, the block raises done and shows the verdict until the next start.

The adder is purely combinational, so the operand and result pins carry no handshake and apply no back-pressure. The result must be valid whenever the settle interval ends.

Top module: `adder_bist_seq`

## Requirements
- R1: A synchronous active-high reset, even in the middle of a run, drives the block to idle. After reset busy, done, pass and fail are 0, first_fail_idx and mismatch_cnt are 0, and both operand outputs are 0.
- R2: start begins a run when the block is idle or done. A start seen while busy has no effect: the run keeps its vector position and its total length.
- R3: The run applies these (A, B) pairs in this order, vectors 1 to 10: (0,0), (0x55555555,0), (0,0x55555555), (0x55555555,0x55555555), (0xAAAAAAAA,0), (0,0xAAAAAAAA), (0xAAAAAAAA,0xAAAAAAAA), (0xFFFFFFFF,0xFFFFFFFF), (0x00000001,0xFFFFFFFF), (0xFFFFFFFF,0x00000001).
- R4: Each vector spends 1 apply cycle, SETTLE = VEC_PERIOD_NS/CLK_PERIOD_NS wait cycles (minimum 1) and 1 check cycle. With defaults (20 ns clock) busy stays high for exactly 10*(5+2) = 70 cycles after the start edge.
- R5: In the check cycle, sum_in is compared with (A+B) mod 2^W. A fault-free adder ends the run with pass=1 and fail=0.
- R6: The first mismatching vector sets fail and loads first_fail_idx with its number (1 to 10). Later mismatches leave first_fail_idx unchanged.
- R7: All ten vectors are applied even after a failure, and mismatch_cnt holds the number of mismatching vectors.
- R8: At the end of a run busy is 0 and done is 1, and pass = done AND NOT fail. done stays high until the next start.
- R9: A new start clears fail, pass, first_fail_idx and mismatch_cnt before the first vector is checked.
- R10: While busy is low, both operand outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a test run (idle or done only) |
| sum_in | input | W | Result from the adder under test |
| opnd_a | output | W | First operand to the adder |
| opnd_b | output | W | Second operand to the adder |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run finished, verdict valid |
| pass | output | 1 | Finished with no mismatch |
| fail | output | 1 | At least one mismatch seen |
| first_fail_idx | output | 4 | Number (1..10) of the first failing vector, 0 if none |
| mismatch_cnt | output | 4 | Count of mismatching vectors in the run |

## Verification
The assertions assume that reset is asserted from the first cycle, so every $past they use refers to a cycle after reset. They also assume that start is a clean synchronous level and that sum_in is settled by the check cycle. The bench meets this by holding reset for several cycles at time zero and by changing start only on falling edges. Its adder models are combinational functions of the operand pins, so their results are stable long before each check. Faulty models, including a stuck-at-0 sum bit and a cell whose carry-out ignores its incoming carry, keep within the same assumptions.

// File: rtl/adder_bist_pkg.sv
package adder_bist_pkg;
  localparam int NUM_VEC = 10;
  localparam int IDX_W   = 4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_APPLY,
    ST_WAIT,
    ST_CHECK,
    ST_DONE
  } bist_state_e;
endpackage

// File: rtl/bist_vec_rom.sv
module bist_vec_rom
  import adder_bist_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [IDX_W-1:0] idx,
  output logic [W-1:0]     vec_a,
  output logic [W-1:0]     vec_b
);
  localparam logic [W-1:0] P_ZERO = '0;
  localparam logic [W-1:0] P_ONES = '1;
  localparam logic [W-1:0] P_EVEN = {(W/2){2'b01}};
  localparam logic [W-1:0] P_ODD  = {(W/2){2'b10}};
  localparam logic [W-1:0] P_LSB  = {{(W-1){1'b0}}, 1'b1};

  // Order matters: vector number reported on failure is idx+1.
  always_comb begin
    unique case (idx)
      4'd0:    begin vec_a = P_ZERO; vec_b = P_ZERO; end
      4'd1:    begin vec_a = P_EVEN; vec_b = P_ZERO; end
      4'd2:    begin vec_a = P_ZERO; vec_b = P_EVEN; end
      4'd3:    begin vec_a = P_EVEN; vec_b = P_EVEN; end
      4'd4:    begin vec_a = P_ODD;  vec_b = P_ZERO; end
      4'd5:    begin vec_a = P_ZERO; vec_b = P_ODD;  end
      4'd6:    begin vec_a = P_ODD;  vec_b = P_ODD;  end
      4'd7:    begin vec_a = P_ONES; vec_b = P_ONES; end
      4'd8:    begin vec_a = P_LSB;  vec_b = P_ONES; end
      4'd9:    begin vec_a = P_ONES; vec_b = P_LSB;  end
      default: begin vec_a = P_ZERO; vec_b = P_ZERO; end
    endcase
  end
endmodule

// File: rtl/bist_settle_timer.sv
module bist_settle_timer #(
  parameter int SETTLE = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  output logic expired
);
  localparam int CNT_W = $clog2(SETTLE + 1) + 1;

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (load)        cnt <= CNT_W'(SETTLE);
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == CNT_W'(1));

  // R4: the settle window ends once per load
  a_r4_single_expiry: assert property (@(posedge clk) disable iff (rst)
    (expired && !load) |=> !expired);
endmodule

// File: rtl/bist_result_tally.sv
module bist_result_tally
  import adder_bist_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             check_en,
  input  logic             mismatch,
  input  logic [IDX_W-1:0] vec_num,
  output logic             fail,
  output logic [IDX_W-1:0] first_idx,
  output logic [IDX_W-1:0] count
);
  always_ff @(posedge clk) begin
    if (rst || clear) begin
      fail      <= 1'b0;
      first_idx <= '0;
      count     <= '0;
    end else if (check_en && mismatch) begin
      count <= count + 1'b1;
      if (!fail) begin
        fail      <= 1'b1;
        first_idx <= vec_num;
      end
    end
  end

  // R6: a recorded index is a legal vector number
  a_r6_first_idx_range: assert property (@(posedge clk) disable iff (rst)
    fail |-> (first_idx >= IDX_W'(1) && first_idx <= IDX_W'(NUM_VEC)));

  // R6: first failing index is never overwritten within a run
  a_r6_first_idx_hold: assert property (@(posedge clk) disable iff (rst)
    (fail && !clear) |=> (first_idx == $past(first_idx)));

  // R7: mismatch count advances by at most one per cycle within a run
  a_r7_count_step: assert property (@(posedge clk) disable iff (rst)
    !clear |=> (count == $past(count) || count == $past(count) + IDX_W'(1)));
endmodule

// File: rtl/adder_bist_seq.sv
module adder_bist_seq
  import adder_bist_pkg::*;
#(
  parameter int W             = 32,
  parameter int CLK_PERIOD_NS = 20,
  parameter int VEC_PERIOD_NS = 100
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [W-1:0]     sum_in,
  output logic [W-1:0]     opnd_a,
  output logic [W-1:0]     opnd_b,
  output logic             busy,
  output logic             done,
  output logic             pass,
  output logic             fail,
  output logic [IDX_W-1:0] first_fail_idx,
  output logic [IDX_W-1:0] mismatch_cnt
);
  localparam int RAW_SETTLE = VEC_PERIOD_NS / CLK_PERIOD_NS;
  localparam int SETTLE     = (RAW_SETTLE < 1) ? 1 : RAW_SETTLE;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_VEC - 1);

  bist_state_e      state;
  logic [IDX_W-1:0] vec_idx;
  logic [W-1:0]     rom_a, rom_b;
  logic [W-1:0]     expected;
  logic             expired;
  logic             launch;

  assign launch = start && (state == ST_IDLE || state == ST_DONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      vec_idx <= '0;
    end else begin
      unique case (state)
        ST_IDLE, ST_DONE: begin
          if (start) begin
            state   <= ST_APPLY;
            vec_idx <= '0;
          end
        end
        ST_APPLY: state <= ST_WAIT;
        ST_WAIT:  if (expired) state <= ST_CHECK;
        ST_CHECK: begin
          if (vec_idx == LAST_IDX) begin
            state <= ST_DONE;
          end else begin
            vec_idx <= vec_idx + 1'b1;
            state   <= ST_APPLY;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  bist_vec_rom #(.W(W)) u_rom (
    .idx   (vec_idx),
    .vec_a (rom_a),
    .vec_b (rom_b)
  );

  bist_settle_timer #(.SETTLE(SETTLE)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .load    (state == ST_APPLY),
    .expired (expired)
  );

  assign expected = rom_a + rom_b;

  bist_result_tally u_tally (
    .clk       (clk),
    .rst       (rst),
    .clear     (launch),
    .check_en  (state == ST_CHECK),
    .mismatch  (sum_in != expected),
    .vec_num   (vec_idx + 1'b1),
    .fail      (fail),
    .first_idx (first_fail_idx),
    .count     (mismatch_cnt)
  );

  assign busy   = (state == ST_APPLY) || (state == ST_WAIT) || (state == ST_CHECK);
  assign done   = (state == ST_DONE);
  assign pass   = done && !fail;
  assign opnd_a = busy ? rom_a : '0;
  assign opnd_b = busy ? rom_b : '0;

  // R8: busy and done are exclusive
  a_r8_busy_done_excl: assert property (@(posedge clk) disable iff (rst)
    !(busy && done));

  // R8: done holds until a new start
  a_r8_done_hold: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> done);

  // R2: start during the settle wait does not restart the run
  a_r2_start_ignored: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WAIT && start) |=> (state == ST_WAIT || state == ST_CHECK));

  // R10: operand pins are quiet outside a run
  a_r10_quiet_operands: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (opnd_a == '0 && opnd_b == '0));
endmodule

// File: tb/test_adder_bist_seq.sv
module test_adder_bist_seq;
  localparam int W      = 32;
  localparam int SETTLE = 5;

  // {A, B, expected sum}
  localparam logic [95:0] VEC_TAB [10] = '{
    {32'h00000000, 32'h00000000, 32'h00000000},
    {32'h55555555, 32'h00000000, 32'h55555555},
    {32'h00000000, 32'h55555555, 32'h55555555},
    {32'h55555555, 32'h55555555, 32'hAAAAAAAA},
    {32'hAAAAAAAA, 32'h00000000, 32'hAAAAAAAA},
    {32'h00000000, 32'hAAAAAAAA, 32'hAAAAAAAA},
    {32'hAAAAAAAA, 32'hAAAAAAAA, 32'h55555554},
    {32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFE},
    {32'h00000001, 32'hFFFFFFFF, 32'h00000000},
    {32'hFFFFFFFF, 32'h00000001, 32'h00000000}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [W-1:0] sum_in, opnd_a, opnd_b;
  logic busy, done, pass, fail;
  logic [3:0] first_fail_idx, mismatch_cnt;
  int fault_mode = 0;
  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  // Adder model: 0 good, 1 sum bit 6 stuck at 0, 2 cell 9 carry-out ignores carry-in
  function automatic logic [W-1:0] model_add(logic [W-1:0] a, logic [W-1:0] b, int mode);
    logic [W-1:0] s;
    logic c;
    c = 1'b0;
    for (int i = 0; i < W; i++) begin
      s[i] = a[i] ^ b[i] ^ c;
      if (mode == 2 && i == 9) c = a[i] & b[i];
      else c = (a[i] & b[i]) | (c & (a[i] ^ b[i]));
    end
    if (mode == 1) s[6] = 1'b0;
    return s;
  endfunction

  always_comb sum_in = model_add(opnd_a, opnd_b, fault_mode);

  adder_bist_seq #(.W(W), .CLK_PERIOD_NS(20), .VEC_PERIOD_NS(100)) i_adder_bist_seq (
    .clk(clk), .rst(rst), .start(start), .sum_in(sum_in),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .busy(busy), .done(done),
    .pass(pass), .fail(fail), .first_fail_idx(first_fail_idx),
    .mismatch_cnt(mismatch_cnt)
  );

  task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Runs one test; start is raised at a falling edge.
  task automatic run(int mode, bit check_ops, bit inject_start,
                     logic exp_fail, logic [3:0] exp_idx, logic [3:0] exp_cnt);
    fault_mode = mode;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R9 fail cleared", 32'(fail), 32'd0);
    chk("R9 count cleared", 32'(mismatch_cnt), 32'd0);
    for (int i = 0; i < 10; i++) begin
      if (check_ops) begin
        chk($sformatf("R3 vec%0d A", i + 1), opnd_a, VEC_TAB[i][95:64]);
        chk($sformatf("R3 vec%0d B", i + 1), opnd_b, VEC_TAB[i][63:32]);
      end
      if (inject_start && i == 3) begin
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (SETTLE) @(negedge clk);
      end else begin
        repeat (SETTLE + 1) @(negedge clk);
      end
      if (i == 9) chk("R4 busy in last cycle", 32'(busy), 32'd1);
      @(negedge clk);
    end
    chk("R4 busy low after 70 cycles", 32'(busy), 32'd0);
    chk("R8 done", 32'(done), 32'd1);
    chk("R5 fail flag", 32'(fail), 32'(exp_fail));
    chk("R8 pass", 32'(pass), 32'(!exp_fail));
    chk("R6 first fail index", 32'(first_fail_idx), 32'(exp_idx));
    chk("R7 mismatch count", 32'(mismatch_cnt), 32'(exp_cnt));
    chk("R10 operand A idle", opnd_a, 32'd0);
    chk("R10 operand B idle", opnd_b, 32'd0);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=<20000", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    chk("R1 busy", 32'(busy), 32'd0);
    chk("R1 done", 32'(done), 32'd0);
    chk("R1 fail", 32'(fail), 32'd0);
    chk("R1 pass", 32'(pass), 32'd0);
    chk("R1 idx", 32'(first_fail_idx), 32'd0);
    chk("R1 count", 32'(mismatch_cnt), 32'd0);
    chk("R1 opnd_a", opnd_a, 32'd0);

    // Table walk with a good adder (R3, R4, R5)
    run(0, 1'b1, 1'b0, 1'b0, 4'd0, 4'd0);
    // R8: done holds
    repeat (5) @(negedge clk);
    chk("R8 done held", 32'(done), 32'd1);

    // R6, R7: stuck-at-0 on sum bit 6 -> vectors 2,3,7,8 fail
    run(1, 1'b0, 1'b0, 1'b1, 4'd2, 4'd4);
    // R9, R6: carry fault in cell 9 -> vectors 9,10 fail
    run(2, 1'b0, 1'b0, 1'b1, 4'd9, 4'd2);
    // R2: start during run ignored; R9 clears previous failure
    run(0, 1'b1, 1'b1, 1'b0, 4'd0, 4'd0);

    // R1: reset in mid-run
    fault_mode = 1;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (20) @(negedge clk);
    chk("R1 busy before mid reset", 32'(busy), 32'd1);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R1 mid-run busy", 32'(busy), 32'd0);
    chk("R1 mid-run done", 32'(done), 32'd0);
    chk("R1 mid-run fail", 32'(fail), 32'd0);
    chk("R1 mid-run count", 32'(mismatch_cnt), 32'd0);
    chk("R1 mid-run opnd_b", opnd_b, 32'd0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule